// File: doc/BRIEF.md
# Exception Arbiter and Vector Sequencer

This block sits beside a processor core's instruction sequencer and decides, at each instruction boundary, which exception the core takes next. Hardware requests (reset, power-on, abort, NMI, IRQ) and a software trap request (BRK or COP) are ranked by a fixed priority. The block then emits the 16-bit bank-zero vector address, the kind of exception, the stack frame to push and the status value the core adopts afterwards. The vector address comes from one of two tables, chosen by the emulation/native mode input.

The decision leaves the block on a valid/ready channel. `vec_valid` rises one cycle after a qualifying `boundary` strobe. The vector, kind, frame and side-effect fields stay stable until the bus sequencer asserts `vec_ready` in a cycle with `vec_valid` high. That sequencer pushes the frame and fetches the vector. While a decision is waiting for acceptance, further boundary strobes are ignored, so back-pressure only delays the transfer and never drops or replaces it. Pushing the frame, fetching the vector and the program-bank clear that acceptance implies are left to the consumer.

The block also tracks the two wait instructions. After `wai_cmd` it reports `stalled` until reset, power-on, IRQ (masked or not) or NMI is pending. After `stp_cmd` only reset or power-on ends the stall.

Top module: `exc_vector_seq`

## Requirements
- R1: After `rst_n` is released, `vec_valid` and `stalled` are 0, no NMI is pending, and a boundary with no request in flight produces no vector.
- R2: Among eligible requests, the winner is reset/power-on, then abort, then NMI, then IRQ, then the software trap. `vec_kind` encodes reset=0, abort=1, NMI=2, IRQ=3, BRK=4, COP=5.
- R3: The vector addresses are as follows. Reset is FFFC in both modes. In emulation mode: abort FFF8, NMI FFFA, IRQ FFFE, BRK FFFE, COP FFF4. In native mode: abort FFE8, NMI FFEA, IRQ FFEE, BRK FFE6, COP FFE4. `sw_cop` high selects COP and low selects BRK.
- R4: IRQ is eligible only while `irq_disable` is 0. Reset, power-on, abort and NMI are eligible regardless of it.
- R5: NMI is taken once per rising edge of `nmi_in`. It stays pending after the line falls until it is taken, and holding the line high does not cause a second take.
- R6: In emulation mode `frame_len` is 3 and `frame_data` is {8'h00, PC[15:8], PC[7:0], status}. In native mode `frame_len` is 4 and `frame_data` is {program bank, PC[15:8], PC[7:0], status}. In both, the first byte to push is the most significant byte.
- R7: In emulation mode, status bit 4 in the frame is cleared for the hardware kinds (0..3). It is passed unchanged for BRK and COP, and passed unchanged in native mode.
- R8: `next_status` is the frame's status with bit 2 (interrupt disable) set and bit 3 (decimal) cleared. `clr_dbr` is 1 only for a reset taken in emulation mode.
- R9: On a rising edge of `abort_req`, `insn_pc`, `cur_pbr` and `cur_status` are captured. An abort decision builds its frame from that capture, presents the capture on `snap_*`, and raises `restore_snap`. `restore_snap` is 0 for all other kinds.
- R10: Once `vec_valid` is 1, it and all decision fields hold unchanged until a cycle with `vec_ready` high. Boundary strobes in the meantime are ignored.
- R11: `wai_cmd` sets `stalled` on the next cycle. The stall ends once reset, power-on, NMI or IRQ is pending, with IRQ counted even when masked. No decision is made while stalled.
- R12: `stp_cmd` sets `stalled` and only reset or power-on ends it. Pending IRQ or NMI does not end it, and a pending NMI is still taken later.
- R13: A decision is made only on a cycle with `boundary` high. Request inputs take one cycle to become pending, and `vec_valid` rises on the cycle after the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset request, level |
| pwr_on_req | input | 1 | Power-on request, level |
| abort_req | input | 1 | Abort request, level; rising edge captures snapshot |
| nmi_in | input | 1 | NMI line, rising-edge sensitive |
| irq_req | input | 1 | IRQ request, level |
| sw_req | input | 1 | Software trap pending at this boundary |
| sw_cop | input | 1 | Software trap is COP (1) or BRK (0) |
| boundary | input | 1 | Instruction boundary strobe |
| emu_mode | input | 1 | Emulation mode (1) or native mode (0) |
| irq_disable | input | 1 | Interrupt-disable status flag |
| wai_cmd | input | 1 | Enter wait-for-interrupt |
| stp_cmd | input | 1 | Enter stop-until-reset |
| insn_pc | input | 16 | PC of the current instruction |
| cur_pbr | input | 8 | Current program bank |
| cur_status | input | 8 | Current status byte |
| vec_ready | input | 1 | Consumer accepts the decision |
| vec_valid | output | 1 | Decision available |
| vec_addr | output | 16 | Bank-zero vector address |
| vec_kind | output | 3 | Exception kind code |
| frame_len | output | 3 | Stack frame byte count |
| frame_data | output | 32 | Stack frame bytes, push order from MSB |
| next_status | output | 8 | Status after exception entry |
| clr_dbr | output | 1 | Clear data bank |
| restore_snap | output | 1 | Restore the abort snapshot |
| snap_pc | output | 16 | Captured PC |
| snap_pbr | output | 8 | Captured program bank |
| snap_status | output | 8 | Captured status |
| stalled | output | 1 | Core held by a wait or stop |

## Verification
The hardest case to reach from the ports is a request that loses or is blocked and must survive to be taken later. One example is an NMI edge that arrives while a stop is in force, or while an earlier decision is stalled by a low `vec_ready`. The bench raises the NMI edge in those windows and confirms that no decision appears. It then releases the blocker (reset for the stop, the handshake for back-pressure) and drains with further boundaries, expecting an NMI decision at the end. The abort snapshot is checked by changing `insn_pc` and `cur_status` after the abort edge and before the boundary.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int ST_I = 2;
  localparam int ST_D = 3;
  localparam int ST_B = 4;

  typedef enum logic [2:0] {
    K_RESET = 3'd0,
    K_ABORT = 3'd1,
    K_NMI   = 3'd2,
    K_IRQ   = 3'd3,
    K_BRK   = 3'd4,
    K_COP   = 3'd5
  } kind_e;

  typedef struct packed {
    logic rst;
    logic pwr;
    logic abt;
    logic nmi;
    logic irq;
  } pend_t;

  typedef enum logic [1:0] {W_IDLE, W_WAI, W_STP} wait_e;

  function automatic logic [AW-1:0] vector_of(kind_e k, logic emu);
    logic [AW-1:0] v;
    case (k)
      K_RESET: v = 16'hFFFC;
      K_ABORT: v = emu ? 16'hFFF8 : 16'hFFE8;
      K_NMI:   v = emu ? 16'hFFFA : 16'hFFEA;
      K_IRQ:   v = emu ? 16'hFFFE : 16'hFFEE;
      K_BRK:   v = emu ? 16'hFFFE : 16'hFFE6;
      default: v = emu ? 16'hFFF4 : 16'hFFE4;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/evs_arbiter.sv
module evs_arbiter
  import evs_pkg::*;
(
  input  pend_t pend,
  input  logic  irq_en,
  input  logic  sw_req,
  input  logic  sw_cop,
  output logic  hit,
  output kind_e kind
);
  always_comb begin
    hit  = 1'b1;
    kind = K_RESET;
    if (pend.rst || pend.pwr)  kind = K_RESET;
    else if (pend.abt)         kind = K_ABORT;
    else if (pend.nmi)         kind = K_NMI;
    else if (pend.irq && irq_en) kind = K_IRQ;
    else if (sw_req)           kind = sw_cop ? K_COP : K_BRK;
    else                       hit = 1'b0;
  end
endmodule

// File: rtl/evs_frame.sv
module evs_frame
  import evs_pkg::*;
#(
  parameter int PW = evs_pkg::AW,
  parameter int BW = evs_pkg::DW,
  localparam int FW = 4 * BW
) (
  input  logic          emu,
  input  kind_e         kind,
  input  logic [PW-1:0] pc,
  input  logic [BW-1:0] pbr,
  input  logic [BW-1:0] status,
  output logic [2:0]    len,
  output logic [FW-1:0] data,
  output logic [BW-1:0] nxt_status
);
  logic [BW-1:0] st;
  logic          hw;

  always_comb begin
    hw = (kind == K_RESET) || (kind == K_ABORT) || (kind == K_NMI) || (kind == K_IRQ);
    st = status;
    if (emu && hw) st[ST_B] = 1'b0;
    nxt_status        = st;
    nxt_status[ST_I]  = 1'b1;
    nxt_status[ST_D]  = 1'b0;
    if (emu) begin
      len  = 3'd3;
      data = {{BW{1'b0}}, pc, st};
    end else begin
      len  = 3'd4;
      data = {pbr, pc, st};
    end
  end
endmodule

// File: rtl/exc_vector_seq.sv
module exc_vector_seq
  import evs_pkg::*;
#(
  parameter int PW = evs_pkg::AW,
  parameter int BW = evs_pkg::DW,
  localparam int FW = 4 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_req,
  input  logic          pwr_on_req,
  input  logic          abort_req,
  input  logic          nmi_in,
  input  logic          irq_req,
  input  logic          sw_req,
  input  logic          sw_cop,
  input  logic          boundary,
  input  logic          emu_mode,
  input  logic          irq_disable,
  input  logic          wai_cmd,
  input  logic          stp_cmd,
  input  logic [PW-1:0] insn_pc,
  input  logic [BW-1:0] cur_pbr,
  input  logic [BW-1:0] cur_status,
  input  logic          vec_ready,
  output logic          vec_valid,
  output logic [PW-1:0] vec_addr,
  output logic [2:0]    vec_kind,
  output logic [2:0]    frame_len,
  output logic [FW-1:0] frame_data,
  output logic [BW-1:0] next_status,
  output logic          clr_dbr,
  output logic          restore_snap,
  output logic [PW-1:0] snap_pc,
  output logic [BW-1:0] snap_pbr,
  output logic [BW-1:0] snap_status,
  output logic          stalled
);
  pend_t pend_q;
  logic  nmi_d, abt_d;
  wait_e wait_q;

  logic  hit;
  kind_e kind;
  logic  take;
  logic  nmi_edge, abt_edge;
  logic  rel_wai, rel_stp;

  logic [PW-1:0] src_pc;
  logic [BW-1:0] src_pbr, src_st;
  logic [2:0]    f_len;
  logic [FW-1:0] f_data;
  logic [BW-1:0] f_nst;

  assign nmi_edge = nmi_in && !nmi_d;
  assign abt_edge = abort_req && !abt_d;
  assign stalled  = (wait_q != W_IDLE);
  assign take     = boundary && !vec_valid && !stalled && hit;
  assign rel_stp  = pend_q.rst || pend_q.pwr;
  assign rel_wai  = rel_stp || pend_q.nmi || pend_q.irq;

  evs_arbiter u_arb (
    .pend   (pend_q),
    .irq_en (!irq_disable),
    .sw_req (sw_req),
    .sw_cop (sw_cop),
    .hit    (hit),
    .kind   (kind)
  );

  always_comb begin
    if (kind == K_ABORT) begin
      src_pc  = snap_pc;
      src_pbr = snap_pbr;
      src_st  = snap_status;
    end else begin
      src_pc  = insn_pc;
      src_pbr = cur_pbr;
      src_st  = cur_status;
    end
  end

  evs_frame #(.PW(PW), .BW(BW)) u_frm (
    .emu        (emu_mode),
    .kind       (kind),
    .pc         (src_pc),
    .pbr        (src_pbr),
    .status     (src_st),
    .len        (f_len),
    .data       (f_data),
    .nxt_status (f_nst)
  );

  // pending requests and edge history
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      nmi_d  <= 1'b0;
      abt_d  <= 1'b0;
    end else begin
      nmi_d      <= nmi_in;
      abt_d      <= abort_req;
      pend_q.rst <= reset_req;
      pend_q.pwr <= pwr_on_req;
      pend_q.abt <= abort_req;
      pend_q.irq <= irq_req;
      if (nmi_edge)                   pend_q.nmi <= 1'b1;
      else if (take && kind == K_NMI) pend_q.nmi <= 1'b0;
    end
  end

  // abort snapshot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_pc     <= '0;
      snap_pbr    <= '0;
      snap_status <= '0;
    end else if (abt_edge) begin
      snap_pc     <= insn_pc;
      snap_pbr    <= cur_pbr;
      snap_status <= cur_status;
    end
  end

  // wait / stop tracking
  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= W_IDLE;
    else begin
      case (wait_q)
        W_IDLE:  if (stp_cmd) wait_q <= W_STP;
                 else if (wai_cmd) wait_q <= W_WAI;
        W_WAI:   if (rel_wai) wait_q <= W_IDLE;
        default: if (rel_stp) wait_q <= W_IDLE;
      endcase
    end
  end

  // decision output channel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid    <= 1'b0;
      vec_addr     <= '0;
      vec_kind     <= '0;
      frame_len    <= '0;
      frame_data   <= '0;
      next_status  <= '0;
      clr_dbr      <= 1'b0;
      restore_snap <= 1'b0;
    end else if (take) begin
      vec_valid    <= 1'b1;
      vec_addr     <= vector_of(kind, emu_mode);
      vec_kind     <= kind;
      frame_len    <= f_len;
      frame_data   <= f_data;
      next_status  <= f_nst;
      clr_dbr      <= (kind == K_RESET) && emu_mode;
      restore_snap <= (kind == K_ABORT);
    end else if (vec_valid && vec_ready) begin
      vec_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
  parameter int PW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic          vec_valid,
  input logic          vec_ready,
  input logic [PW-1:0] vec_addr,
  input logic [2:0]    vec_kind,
  input logic [2:0]    frame_len,
  input logic [4*BW-1:0] frame_data,
  input logic [BW-1:0] next_status,
  input logic          clr_dbr,
  input logic          stalled
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr) && $stable(vec_kind)
                                && $stable(frame_data))
    else $error("p_hold_r10");

  p_needs_boundary_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(boundary))
    else $error("p_needs_boundary_r13");

  p_frame_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (frame_len == 3'd4) ||
                  (frame_len == 3'd3 && frame_data[4*BW-1:3*BW] == '0))
    else $error("p_frame_shape_r6");

  p_status_fx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> next_status[2] && !next_status[3])
    else $error("p_status_fx_r8");

  p_dbr_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && clr_dbr |-> vec_kind == 3'd0 && frame_len == 3'd3)
    else $error("p_dbr_reset_r8");

  p_reset_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_kind == 3'd0 |-> vec_addr == 16'hFFFC)
    else $error("p_reset_vec_r3");

  p_no_take_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stalled && !vec_valid |=> !vec_valid)
    else $error("p_no_take_stalled_r11");
endmodule

bind exc_vector_seq evs_checker #(.PW(PW), .BW(BW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .boundary    (boundary),
  .vec_valid   (vec_valid),
  .vec_ready   (vec_ready),
  .vec_addr    (vec_addr),
  .vec_kind    (vec_kind),
  .frame_len   (frame_len),
  .frame_data  (frame_data),
  .next_status (next_status),
  .clr_dbr     (clr_dbr),
  .stalled     (stalled)
);

// File: tb/sim_exc_vector_seq.sv
module sim_exc_vector_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req = 0, pwr_on_req = 0, abort_req = 0, nmi_in = 0, irq_req = 0;
  logic sw_req = 0, sw_cop = 0, boundary = 0, emu_mode = 0, irq_disable = 0;
  logic wai_cmd = 0, stp_cmd = 0, vec_ready = 0;
  logic [15:0] insn_pc = 16'h1234;
  logic [7:0]  cur_pbr = 8'h5A, cur_status = 8'hFF;
  logic vec_valid, clr_dbr, restore_snap, stalled;
  logic [15:0] vec_addr, snap_pc;
  logic [2:0]  vec_kind, frame_len;
  logic [31:0] frame_data;
  logic [7:0]  next_status, snap_pbr, snap_status;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  exc_vector_seq u0 (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .pwr_on_req(pwr_on_req),
    .abort_req(abort_req), .nmi_in(nmi_in), .irq_req(irq_req), .sw_req(sw_req),
    .sw_cop(sw_cop), .boundary(boundary), .emu_mode(emu_mode),
    .irq_disable(irq_disable), .wai_cmd(wai_cmd), .stp_cmd(stp_cmd),
    .insn_pc(insn_pc), .cur_pbr(cur_pbr), .cur_status(cur_status),
    .vec_ready(vec_ready), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .vec_kind(vec_kind), .frame_len(frame_len), .frame_data(frame_data),
    .next_status(next_status), .clr_dbr(clr_dbr), .restore_snap(restore_snap),
    .snap_pc(snap_pc), .snap_pbr(snap_pbr), .snap_status(snap_status),
    .stalled(stalled)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {emu, idis, rst, pwr, abt, nmi, irq, sw, cop, kind[2:0], addr[15:0]}
  localparam int NV = 14;
  localparam logic [27:0] VT [NV] = '{
    {9'b1_0_00001_00, 3'd3, 16'hFFFE},
    {9'b0_0_00001_00, 3'd3, 16'hFFEE},
    {9'b1_1_00001_00, 3'd7, 16'h0000},
    {9'b0_1_00001_10, 3'd4, 16'hFFE6},
    {9'b1_0_00000_10, 3'd4, 16'hFFFE},
    {9'b1_0_00000_11, 3'd5, 16'hFFF4},
    {9'b0_0_00000_11, 3'd5, 16'hFFE4},
    {9'b1_0_00011_00, 3'd2, 16'hFFFA},
    {9'b0_0_00011_10, 3'd2, 16'hFFEA},
    {9'b1_0_00110_00, 3'd1, 16'hFFF8},
    {9'b0_0_00101_00, 3'd1, 16'hFFE8},
    {9'b0_0_10110_00, 3'd0, 16'hFFFC},
    {9'b1_0_01001_00, 3'd0, 16'hFFFC},
    {9'b0_1_00010_00, 3'd2, 16'hFFEA}
  };

  task automatic accept();
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
      if (vec_valid) accept();
    end
  endtask

  task automatic expect_frame(input string tag, input logic emu, input logic [2:0] kind,
                              input logic [15:0] pc, input logic [7:0] pbr,
                              input logic [7:0] st_in);
    logic [7:0] st, ns;
    st = st_in;
    if (emu && kind <= 3'd3) st[4] = 1'b0;
    ns = st;
    ns[2] = 1'b1;
    ns[3] = 1'b0;
    chk({tag, " R6 len"}, {29'd0, frame_len}, emu ? 32'd3 : 32'd4);
    chk({tag, " R6 R7 data"}, frame_data, emu ? {8'h00, pc, st} : {pbr, pc, st});
    chk({tag, " R8 nst"}, {24'd0, next_status}, {24'd0, ns});
    chk({tag, " R8 dbr"}, {31'd0, clr_dbr}, {31'd0, (kind == 3'd0) && emu});
    chk({tag, " R9 restore"}, {31'd0, restore_snap}, {31'd0, kind == 3'd1});
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'd0, vec_valid}, 0);
    chk("R1 stalled", {31'd0, stalled}, 0);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk("R1 no pending", {31'd0, vec_valid}, 0);

    // table: R2 R3 R4 R13
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VT[i];
      emu_mode = v[27]; irq_disable = v[26]; reset_req = v[25]; pwr_on_req = v[24];
      abort_req = v[23]; nmi_in = v[22]; irq_req = v[21]; sw_req = v[20]; sw_cop = v[19];
      @(negedge clk);
      nmi_in = 1'b0;
      chk($sformatf("R13 no boundary case%0d", i), {31'd0, vec_valid}, 0);
      boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
      sw_req = 1'b0;
      if (v[18:16] == 3'd7) begin
        chk($sformatf("R4 masked case%0d", i), {31'd0, vec_valid}, 0);
      end else begin
        chk($sformatf("R13 valid case%0d", i), {31'd0, vec_valid}, 1);
        chk($sformatf("R2 kind case%0d", i), {29'd0, vec_kind}, {29'd0, v[18:16]});
        chk($sformatf("R3 addr case%0d", i), {16'd0, vec_addr}, {16'd0, v[15:0]});
        expect_frame($sformatf("case%0d", i), v[27], v[18:16], 16'h1234, 8'h5A, 8'hFF);
        accept();
      end
      reset_req = 0; pwr_on_req = 0; abort_req = 0; irq_req = 0; irq_disable = 0;
      @(negedge clk);
      chk($sformatf("R10 released case%0d", i), {31'd0, vec_valid}, 0);
      drain();
    end

    // R10 back-pressure, R5 NMI survives
    emu_mode = 1; irq_req = 1;
    @(negedge clk);
    boundary = 1;
    @(negedge clk);
    nmi_in = 1;
    @(negedge clk);
    nmi_in = 0; boundary = 0;
    @(negedge clk);
    chk("R10 held valid", {31'd0, vec_valid}, 1);
    chk("R10 held kind", {29'd0, vec_kind}, 3);
    chk("R10 held addr", {16'd0, vec_addr}, 32'hFFFE);
    irq_req = 0;
    accept();
    chk("R10 drop after accept", {31'd0, vec_valid}, 0);
    boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R5 nmi kept pending", {29'd0, vec_kind}, 2);
    chk("R5 nmi valid", {31'd0, vec_valid}, 1);
    accept();

    // R5 held line gives one take
    nmi_in = 1;
    @(negedge clk);
    boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R5 first take", {29'd0, vec_kind}, 2);
    accept();
    boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R5 no retake", {31'd0, vec_valid}, 0);
    nmi_in = 0;

    // R9 abort snapshot
    emu_mode = 0; insn_pc = 16'h2468; cur_status = 8'hC3; abort_req = 1;
    @(negedge clk);
    insn_pc = 16'h9999; cur_status = 8'h00; cur_pbr = 8'h11;
    boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R9 kind", {29'd0, vec_kind}, 1);
    chk("R9 snap pc", {16'd0, snap_pc}, 32'h2468);
    expect_frame("R9 abort", 1'b0, 3'd1, 16'h2468, 8'h5A, 8'hC3);
    abort_req = 0;
    accept();
    insn_pc = 16'h1234; cur_status = 8'hFF; cur_pbr = 8'h5A;
    drain();

    // R11 WAI with masked IRQ
    wai_cmd = 1;
    @(negedge clk);
    wai_cmd = 0;
    chk("R11 stall set", {31'd0, stalled}, 1);
    irq_disable = 1; irq_req = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 masked irq releases", {31'd0, stalled}, 0);
    boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R4 R11 no take masked", {31'd0, vec_valid}, 0);
    irq_req = 0; irq_disable = 0;
    @(negedge clk);

    // R12 STP ignores IRQ and NMI
    stp_cmd = 1;
    @(negedge clk);
    stp_cmd = 0; irq_req = 1; nmi_in = 1;
    @(negedge clk);
    nmi_in = 0; boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R12 still stalled", {31'd0, stalled}, 1);
    chk("R12 no take", {31'd0, vec_valid}, 0);
    irq_req = 0; reset_req = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 reset releases", {31'd0, stalled}, 0);
    boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R12 reset taken", {29'd0, vec_kind}, 0);
    reset_req = 0;
    accept();
    boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk("R12 R5 nmi after stop", {29'd0, vec_kind}, 2);
    chk("R12 nmi valid", {31'd0, vec_valid}, 1);
    accept();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule